// File: doc/BRIEF.md
# Tagged Geometric-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A direct-mapped table of two-bit counters, addressed by low branch-address bits, gives a fallback guess. Four tagged banks sit above it. Each bank hashes the branch address with a different amount of global outcome history: 4, 8, 16 and 32 bits, doubling from bank to bank. A 16-bit trail of address bits is mixed into the same hashes. All banks are read in the same cycle. The bank with the most history whose stored tag matches supplies the guess.

The predict port is purely combinational. It takes an address and returns a direction and a code that names the supplying structure. The update port carries the resolved address, the outcome and a wrong-guess flag, and it commits once per clock. On that edge the block trains the supplier and adjusts usefulness counters. When the flag is set it claims an entry in a longer-history bank. Both history registers shift on every accepted update. A synchronous active-low reset empties every bank and clears both histories.

Top module: `tage_predictor`

## Requirements
- R1: After reset every tagged entry is invalid, every base counter is 0 and both histories are 0. Every address therefore predicts not-taken with provider code 0.
- R2: The base table has 256 two-bit counters addressed by pc[7:0]. A counter predicts taken when it is 2 or 3. It counts toward the outcome and saturates at 0 and 3. It is trained only on updates where it is the provider.
- R3: The bank k in 0..3 uses history length L = 4<<k. Its index is pc[5:0]^pc[11:6]^F(ghist,L,6)^F(path,16,6). Its tag is pc[7:0]^F(ghist,L,8)^(F(ghist,L,7)<<1 kept to 8 bits)^path[15:8]. F(h,L,w) has bit j equal to the XOR of every h[b] with b<L and b mod w = j.
- R4: An entry hits when it is valid and its tag equals the computed tag. The hitting bank with the highest number provides the prediction, and pred_provider is k+1 for bank k or 0 for the base table. A tagged entry predicts taken when its signed 3-bit counter is zero or positive.
- R5: On an update, the provider's tagged counter moves one step toward the outcome and saturates at +3 and -4.
- R6: The alternate prediction comes from the next lower hitting bank, or from the base table if no lower bank hits. The provider's 2-bit useful counter goes up, saturating at 3, when the provider was right and the alternate differed. It goes down, saturating at 0, when the provider was wrong and the alternate was right.
- R7: When upd_mispred is set, the lowest-numbered bank above the provider whose useful counter at its computed index is 0 receives a new entry. The entry is marked valid and gets the computed tag, a counter of 0 for taken or -1 for not-taken, and a useful count of 0.
- R8: When upd_mispred is set but no bank above the provider has a zero useful counter, every bank above the provider decrements that counter, stopping at 0. If bank 3 is the provider, nothing is allocated or decremented.
- R9: Each update shifts the outcome into bit 0 of the 32-bit global history. It also shifts upd_pc[2] into bit 0 of the 16-bit path history.
- R10: The prediction depends only on pred_pc and the state as of the last clock edge. A cycle with upd_valid low changes no table and no history.
- R11: Taking reset low in the middle of operation returns the block to the state of R1 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | 32 | Address to be predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_provider | output | 3 | 0 = base table, k+1 = tagged bank k |
| upd_valid | input | 1 | Commit an update on this edge |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_mispred | input | 1 | The earlier prediction was wrong; request allocation |

## Verification
A corrupt counter, tag or valid bit is invisible until a later predict lands on that same hashed entry. At that point it shows up as a wrong direction or a wrong provider code. A fault in a history register is wider. It moves every later tagged lookup to different rows and tags, so the provider codes drift within a few updates of the fault. The bench keeps an independent model of all tables and histories. It compares both outputs before every update, so a divergence is reported at the first address that reaches the damaged state.

// File: rtl/tage_pkg.sv
`timescale 1ns/1ps
package tage_pkg;

  // what a bank does to the useful counter at its update row
  typedef enum logic [1:0] {
    USE_HOLD = 2'd0,
    USE_INC  = 2'd1,
    USE_DEC  = 2'd2
  } use_act_e;

  localparam int FOLD_MAX_W = 16;
  localparam int FOLD_SRC_W = 64;

  // XOR-compress the lowest len bits of src into w bits (w <= FOLD_MAX_W)
  function automatic logic [FOLD_MAX_W-1:0] fold_bits(input logic [FOLD_SRC_W-1:0] src,
                                                      input int len, input int w);
    logic [FOLD_MAX_W-1:0] acc;
    acc = '0;
    for (int b = 0; b < FOLD_SRC_W; b++) begin
      if (b < len) acc = acc ^ (FOLD_MAX_W'(src[b]) << (b % w));
    end
    return acc;
  endfunction

endpackage

// File: rtl/tage_base_table.sv
`timescale 1ns/1ps
module tage_base_table #(
  parameter int IDX_W = 8,
  parameter int CTR_W = 2,
  parameter int PC_W  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  input  logic [PC_W-1:0] upd_pc,
  output logic            pred_dir,
  output logic            upd_dir,
  input  logic            train_en,
  input  logic            train_taken
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_TOP = '1;

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [IDX_W-1:0] pred_i, upd_i;

  assign pred_i   = pred_pc[IDX_W-1:0];
  assign upd_i    = upd_pc[IDX_W-1:0];
  assign pred_dir = ctr_q[pred_i][CTR_W-1];
  assign upd_dir  = ctr_q[upd_i][CTR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) ctr_q[e] <= '0;
    end else if (train_en) begin
      if (train_taken && ctr_q[upd_i] != CTR_TOP) ctr_q[upd_i] <= ctr_q[upd_i] + 1'b1;
      else if (!train_taken && ctr_q[upd_i] != '0) ctr_q[upd_i] <= ctr_q[upd_i] - 1'b1;
    end
  end

  // R2: a saturated-low counter trained not-taken stays at zero
  assert_base_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (train_en && !train_taken && ctr_q[upd_i] == '0) |=> (ctr_q[$past(upd_i)] == '0));

endmodule

// File: rtl/tage_tagged_bank.sv
`timescale 1ns/1ps
module tage_tagged_bank
  import tage_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int TAG_W    = 8,
  parameter int CTR_W    = 3,
  parameter int U_W      = 2,
  parameter int HIST_LEN = 4,
  parameter int GHIST_W  = 32,
  parameter int PATH_W   = 16,
  parameter int PC_W     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_W-1:0]    pred_pc,
  input  logic [PC_W-1:0]    upd_pc,
  input  logic [GHIST_W-1:0] ghist,
  input  logic [PATH_W-1:0]  path,
  output logic               pred_hit,
  output logic               pred_dir,
  output logic               upd_hit,
  output logic               upd_dir,
  output logic               upd_u_zero,
  input  logic               train_en,
  input  logic               train_taken,
  input  use_act_e           use_act,
  input  logic               alloc_en,
  input  logic               alloc_dir
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX    = {1'b0, {(CTR_W-1){1'b1}}};
  localparam logic [CTR_W-1:0] CTR_MIN    = {1'b1, {(CTR_W-1){1'b0}}};
  localparam logic [CTR_W-1:0] CTR_WEAK_T = '0;
  localparam logic [CTR_W-1:0] CTR_WEAK_N = '1;
  localparam logic [U_W-1:0]   U_MAX      = '1;

  function automatic logic [IDX_W-1:0] idx_hash(input logic [PC_W-1:0] pc,
                                                input logic [GHIST_W-1:0] gh,
                                                input logic [PATH_W-1:0] ph);
    logic [FOLD_MAX_W-1:0] fh, fp;
    fh = fold_bits(FOLD_SRC_W'(gh), HIST_LEN, IDX_W);
    fp = fold_bits(FOLD_SRC_W'(ph), PATH_W, IDX_W);
    return pc[IDX_W-1:0] ^ pc[2*IDX_W-1:IDX_W] ^ fh[IDX_W-1:0] ^ fp[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_hash(input logic [PC_W-1:0] pc,
                                                input logic [GHIST_W-1:0] gh,
                                                input logic [PATH_W-1:0] ph);
    logic [FOLD_MAX_W-1:0] fa, fb;
    fa = fold_bits(FOLD_SRC_W'(gh), HIST_LEN, TAG_W);
    fb = fold_bits(FOLD_SRC_W'(gh), HIST_LEN, TAG_W-1);
    return pc[TAG_W-1:0] ^ fa[TAG_W-1:0] ^ {fb[TAG_W-2:0], 1'b0} ^ ph[PATH_W-1 -: TAG_W];
  endfunction

  logic             vld_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [U_W-1:0]   u_q   [DEPTH];

  logic [IDX_W-1:0] pred_i, upd_i;
  logic [TAG_W-1:0] pred_t, upd_t;
  logic [CTR_W-1:0] ctr_next;

  assign pred_i = idx_hash(pred_pc, ghist, path);
  assign pred_t = tag_hash(pred_pc, ghist, path);
  assign upd_i  = idx_hash(upd_pc, ghist, path);
  assign upd_t  = tag_hash(upd_pc, ghist, path);

  assign pred_hit   = vld_q[pred_i] && (tag_q[pred_i] == pred_t);
  assign pred_dir   = !ctr_q[pred_i][CTR_W-1];
  assign upd_hit    = vld_q[upd_i] && (tag_q[upd_i] == upd_t);
  assign upd_dir    = !ctr_q[upd_i][CTR_W-1];
  assign upd_u_zero = (u_q[upd_i] == '0);

  always_comb begin
    ctr_next = ctr_q[upd_i];
    if (train_taken && ctr_q[upd_i] != CTR_MAX) ctr_next = ctr_q[upd_i] + 1'b1;
    else if (!train_taken && ctr_q[upd_i] != CTR_MIN) ctr_next = ctr_q[upd_i] - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        vld_q[e] <= 1'b0;
        tag_q[e] <= '0;
        ctr_q[e] <= '0;
        u_q[e]   <= '0;
      end
    end else begin
      if (train_en) ctr_q[upd_i] <= ctr_next;
      if (use_act == USE_INC && u_q[upd_i] != U_MAX) u_q[upd_i] <= u_q[upd_i] + 1'b1;
      else if (use_act == USE_DEC && u_q[upd_i] != '0) u_q[upd_i] <= u_q[upd_i] - 1'b1;
      if (alloc_en) begin
        vld_q[upd_i] <= 1'b1;
        tag_q[upd_i] <= upd_t;
        ctr_q[upd_i] <= alloc_dir ? CTR_WEAK_T : CTR_WEAK_N;
        u_q[upd_i]   <= '0;
      end
    end
  end

  // R7: a claimed row is valid, carries the update tag and starts not useful
  assert_alloc_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> (vld_q[$past(upd_i)] && u_q[$past(upd_i)] == '0 &&
                  tag_q[$past(upd_i)] == $past(upd_t)));

  // R5: the counter does not wrap past its positive limit
  assert_ctr_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (train_en && train_taken && ctr_q[upd_i] == CTR_MAX) |=> (ctr_q[$past(upd_i)] == CTR_MAX));

endmodule

// File: rtl/tage_provider_pick.sv
`timescale 1ns/1ps
module tage_provider_pick #(
  parameter int N_TABLES = 4,
  parameter int PROV_W   = 3
) (
  input  logic [N_TABLES-1:0] hit,
  input  logic [N_TABLES-1:0] dir,
  input  logic                base_dir,
  output logic [PROV_W-1:0]   prov_id,
  output logic                final_dir,
  output logic                alt_dir
);
  // walk upward: each hit demotes the current winner to alternate
  always_comb begin
    prov_id   = '0;
    final_dir = base_dir;
    alt_dir   = base_dir;
    for (int i = 0; i < N_TABLES; i++) begin
      if (hit[i]) begin
        alt_dir   = final_dir;
        final_dir = dir[i];
        prov_id   = PROV_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/tage_predictor.sv
`timescale 1ns/1ps
module tage_predictor
  import tage_pkg::*;
#(
  parameter int N_TABLES   = 4,
  parameter int TAG_IDX_W  = 6,
  parameter int TAG_W      = 8,
  parameter int CTR_W      = 3,
  parameter int U_W        = 2,
  parameter int BASE_IDX_W = 8,
  parameter int BASE_CTR_W = 2,
  parameter int MIN_HIST   = 4,
  parameter int GHIST_W    = 32,
  parameter int PATH_W     = 16,
  parameter int PC_W       = 32,
  parameter int PATH_BIT   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [PC_W-1:0]                pred_pc,
  output logic                           pred_taken,
  output logic [$clog2(N_TABLES+1)-1:0]  pred_provider,
  input  logic                           upd_valid,
  input  logic [PC_W-1:0]                upd_pc,
  input  logic                           upd_taken,
  input  logic                           upd_mispred
);
  localparam int PROV_W = $clog2(N_TABLES + 1);
  localparam logic [N_TABLES-1:0] ONE_N = N_TABLES'(1);

  logic [GHIST_W-1:0] ghist;
  logic [PATH_W-1:0]  path_h;

  logic [N_TABLES-1:0] p_hit, p_dir, u_hit, u_dir, u_zero;
  logic [N_TABLES-1:0] train_vec, cand_vec, free_vec, alloc_sel;
  logic                alloc_starved;
  use_act_e            use_act [N_TABLES];

  logic              base_pred_dir, base_upd_dir, base_train;
  logic [PROV_W-1:0] upd_prov;
  logic              upd_final, upd_alt, prov_right, alt_right;
  logic              pred_alt_unused;

  tage_base_table #(.IDX_W(BASE_IDX_W), .CTR_W(BASE_CTR_W), .PC_W(PC_W)) u_base (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .upd_pc(upd_pc),
    .pred_dir(base_pred_dir), .upd_dir(base_upd_dir),
    .train_en(base_train), .train_taken(upd_taken)
  );

  for (genvar g = 0; g < N_TABLES; g++) begin : g_bank
    tage_tagged_bank #(
      .IDX_W(TAG_IDX_W), .TAG_W(TAG_W), .CTR_W(CTR_W), .U_W(U_W),
      .HIST_LEN(MIN_HIST << g), .GHIST_W(GHIST_W), .PATH_W(PATH_W), .PC_W(PC_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .upd_pc(upd_pc),
      .ghist(ghist), .path(path_h),
      .pred_hit(p_hit[g]), .pred_dir(p_dir[g]),
      .upd_hit(u_hit[g]), .upd_dir(u_dir[g]), .upd_u_zero(u_zero[g]),
      .train_en(train_vec[g]), .train_taken(upd_taken), .use_act(use_act[g]),
      .alloc_en(alloc_sel[g]), .alloc_dir(upd_taken)
    );
  end

  tage_provider_pick #(.N_TABLES(N_TABLES), .PROV_W(PROV_W)) u_pick_pred (
    .hit(p_hit), .dir(p_dir), .base_dir(base_pred_dir),
    .prov_id(pred_provider), .final_dir(pred_taken), .alt_dir(pred_alt_unused)
  );

  tage_provider_pick #(.N_TABLES(N_TABLES), .PROV_W(PROV_W)) u_pick_upd (
    .hit(u_hit), .dir(u_dir), .base_dir(base_upd_dir),
    .prov_id(upd_prov), .final_dir(upd_final), .alt_dir(upd_alt)
  );

  // update decode: train the provider, rate its usefulness, claim or age above it
  always_comb begin
    prov_right = (upd_final == upd_taken);
    alt_right  = (upd_alt == upd_taken);
    base_train = upd_valid && (upd_prov == '0);
    for (int i = 0; i < N_TABLES; i++) begin
      train_vec[i] = upd_valid && (upd_prov == PROV_W'(i + 1));
      cand_vec[i]  = upd_valid && upd_mispred && (upd_prov <= PROV_W'(i));
    end
    free_vec      = cand_vec & u_zero;
    alloc_sel     = free_vec & (~free_vec + ONE_N);
    alloc_starved = (|cand_vec) && !(|free_vec);
    for (int i = 0; i < N_TABLES; i++) begin
      use_act[i] = USE_HOLD;
      if (train_vec[i]) begin
        if (prov_right && !alt_right)      use_act[i] = USE_INC;
        else if (!prov_right && alt_right) use_act[i] = USE_DEC;
      end else if (alloc_starved && cand_vec[i]) begin
        use_act[i] = USE_DEC;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghist  <= '0;
      path_h <= '0;
    end else if (upd_valid) begin
      ghist  <= {ghist[GHIST_W-2:0], upd_taken};
      path_h <= {path_h[PATH_W-2:0], upd_pc[PATH_BIT]};
    end
  end

  // R9: each accepted update shifts outcome and address bit in at the bottom
  assert_hist_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (ghist == {$past(ghist[GHIST_W-2:0]), $past(upd_taken)} &&
                   path_h == {$past(path_h[PATH_W-2:0]), $past(upd_pc[PATH_BIT])}));

  // R10: idle cycles leave the histories alone
  assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(ghist) && $stable(path_h)));

  // R11: reset clears both histories on the following edge
  assert_reset_clear_R11: assert property (@(posedge clk)
    !rst_n |=> (ghist == '0 && path_h == '0));

endmodule

// File: tb/tage_predictor_tb_top.sv
`timescale 1ns/1ps
module tage_predictor_tb_top;
  localparam int NT   = 4;
  localparam int TDEP = 64;
  localparam int NPASS = 6;
  localparam int NRAND = 1500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken;
  logic [2:0]  pred_provider;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        upd_mispred = 1'b0;

  always #2.5 clk = ~clk;

  tage_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_provider(pred_provider), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_mispred(upd_mispred)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // ---------------- independent model ----------------
  int m_vld [NT][TDEP];
  int m_tag [NT][TDEP];
  int m_ctr [NT][TDEP];
  int m_u   [NT][TDEP];
  int m_bim [256];
  logic [31:0] m_gh;
  logic [15:0] m_ph;

  function automatic void m_reset();
    for (int t = 0; t < NT; t++)
      for (int e = 0; e < TDEP; e++) begin
        m_vld[t][e] = 0; m_tag[t][e] = 0; m_ctr[t][e] = 0; m_u[t][e] = 0;
      end
    for (int e = 0; e < 256; e++) m_bim[e] = 0;
    m_gh = '0;
    m_ph = '0;
  endfunction

  // R3: chunk-wise fold of the lowest len bits into w bits
  function automatic int fold_chunks(logic [63:0] h, int len, int w);
    logic [63:0] hm;
    int r;
    hm = (len >= 64) ? h : (h & ((64'd1 << len) - 64'd1));
    r = 0;
    for (int c = 0; c * w < len; c++) r = r ^ int'((hm >> (c * w)) & ((64'd1 << w) - 64'd1));
    return r;
  endfunction

  function automatic int m_idx(int t, logic [31:0] pc);
    int len;
    len = 4 << t;
    return (int'(pc[5:0]) ^ int'(pc[11:6]) ^ fold_chunks(64'(m_gh), len, 6) ^
            fold_chunks(64'(m_ph), 16, 6)) & 63;
  endfunction

  function automatic int m_tagv(int t, logic [31:0] pc);
    int len;
    len = 4 << t;
    return (int'(pc[7:0]) ^ fold_chunks(64'(m_gh), len, 8) ^
            (fold_chunks(64'(m_gh), len, 7) << 1) ^ int'(m_ph[15:8])) & 255;
  endfunction

  function automatic void m_lookup(logic [31:0] pc, output int prov, output int dir, output int alt);
    int i;
    dir  = (m_bim[pc[7:0]] >= 2) ? 1 : 0;   // R2 fallback guess
    alt  = dir;
    prov = 0;
    for (int t = 0; t < NT; t++) begin
      i = m_idx(t, pc);
      if (m_vld[t][i] != 0 && m_tag[t][i] == m_tagv(t, pc)) begin
        alt  = dir;
        dir  = (m_ctr[t][i] >= 0) ? 1 : 0;
        prov = t + 1;
      end
    end
  endfunction

  function automatic void m_update(logic [31:0] pc, bit tk, bit mis);
    int prov, dir, alt, found, p, tki;
    int ix [NT];
    int tg [NT];
    tki = tk ? 1 : 0;
    m_lookup(pc, prov, dir, alt);
    for (int t = 0; t < NT; t++) begin
      ix[t] = m_idx(t, pc);
      tg[t] = m_tagv(t, pc);
    end
    if (prov == 0) begin
      if (tk && m_bim[pc[7:0]] < 3) m_bim[pc[7:0]]++;
      else if (!tk && m_bim[pc[7:0]] > 0) m_bim[pc[7:0]]--;
    end else begin
      p = prov - 1;
      // R5 saturating direction counter
      if (tk && m_ctr[p][ix[p]] < 3) m_ctr[p][ix[p]]++;
      else if (!tk && m_ctr[p][ix[p]] > -4) m_ctr[p][ix[p]]--;
      // R6 usefulness
      if (dir == tki && alt != tki && m_u[p][ix[p]] < 3) m_u[p][ix[p]]++;
      else if (dir != tki && alt == tki && m_u[p][ix[p]] > 0) m_u[p][ix[p]]--;
    end
    if (mis) begin
      found = -1;
      for (int t = prov; t < NT; t++)
        if (found < 0 && m_u[t][ix[t]] == 0) found = t;
      if (found >= 0) begin                      // R7 claim
        m_vld[found][ix[found]] = 1;
        m_tag[found][ix[found]] = tg[found];
        m_ctr[found][ix[found]] = tk ? 0 : -1;
        m_u[found][ix[found]]   = 0;
      end else begin                             // R8 age
        for (int t = prov; t < NT; t++)
          if (m_u[t][ix[t]] > 0) m_u[t][ix[t]]--;
      end
    end
    m_gh = {m_gh[30:0], tk};                     // R9 histories
    m_ph = {m_ph[14:0], pc[2]};
  endfunction

  // ---------------- checking ----------------
  task automatic check_pred(string req, int ep, int ed);
    n_cmp++;
    if (int'(pred_provider) != ep) begin
      n_bad++;
      $display("FAIL %s provider pc=%h actual=%0d expected=%0d", req, pred_pc, pred_provider, ep);
    end
    n_cmp++;
    if (int'(pred_taken) != ed) begin
      n_bad++;
      $display("FAIL %s direction pc=%h actual=%0d expected=%0d", req, pred_pc, pred_taken, ed);
    end
  endtask

  task automatic probe(string req, logic [31:0] pc);
    int ep, ed, ea;
    @(negedge clk);
    pred_pc = pc;
    #1;
    m_lookup(pc, ep, ed, ea);
    check_pred(req, ep, ed);
  endtask

  task automatic step(logic [31:0] pc, bit tk, bit vld, bit force_mis);
    int ep, ed, ea;
    bit mis;
    @(negedge clk);
    pred_pc   = pc;
    upd_valid = 1'b0;
    #1;
    m_lookup(pc, ep, ed, ea);
    check_pred((ep == 0) ? "R2" : "R4", ep, ed);
    mis         = (ed != (tk ? 1 : 0)) || force_mis;
    upd_pc      = pc;
    upd_taken   = tk;
    upd_mispred = mis;
    upd_valid   = vld;
    @(posedge clk);
    #1;
    if (vld) m_update(pc, tk, mis);
    upd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_reset();
  endtask

  // {pc, outcome}
  localparam logic [32:0] VEC [24] = '{
    {32'h0000_1004, 1'b1}, {32'h0000_2108, 1'b1}, {32'h0000_1004, 1'b0}, {32'h0000_30C0, 1'b1},
    {32'h0000_1004, 1'b1}, {32'h0000_30C0, 1'b1}, {32'h0000_1004, 1'b0}, {32'h0000_30C0, 1'b0},
    {32'h0000_2108, 1'b1}, {32'h0000_1004, 1'b1}, {32'h0000_0FFC, 1'b0}, {32'h0000_1004, 1'b0},
    {32'h0000_30C0, 1'b1}, {32'h0000_2108, 1'b1}, {32'h0000_30C0, 1'b1}, {32'h0000_30C0, 1'b0},
    {32'h0000_1004, 1'b1}, {32'h0000_0FFC, 1'b0}, {32'h0000_1004, 1'b0}, {32'h0000_2108, 1'b0},
    {32'h0000_0FFC, 1'b1}, {32'h0000_1004, 1'b1}, {32'h0000_2108, 1'b1}, {32'h0000_1004, 1'b0}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] lf;
    logic [31:0] pc;
    m_reset();
    do_reset();

    // R1: empty state predicts not-taken from the base table
    probe("R1", 32'h0000_0000);
    probe("R1", 32'h0000_1004);
    probe("R1", 32'hFFFF_FFFC);

    // table walk, several passes so tagged banks fill and train
    for (int p = 0; p < NPASS; p++)
      for (int v = 0; v < 24; v++)
        step(VEC[v][32:1], VEC[v][0], 1'b1, 1'b0);

    // R10: updates with upd_valid low leave everything unchanged
    for (int k = 0; k < 6; k++) step(32'h0000_1004, 1'b1, 1'b0, 1'b1);
    probe("R10", 32'h0000_1004);
    probe("R10", 32'h0000_30C0);
    probe("R10", 32'h0000_2108);

    // R7/R8: forced wrong-guess flags on correct guesses claim and age entries
    for (int k = 0; k < 40; k++) step(32'h0000_2108, 1'b1, 1'b1, 1'b1);
    probe("R7", 32'h0000_2108);

    // mixed stream from a xorshift generator
    lf = 32'h1234_5678;
    for (int k = 0; k < NRAND; k++) begin
      lf = lf ^ (lf << 13);
      lf = lf ^ (lf >> 17);
      lf = lf ^ (lf << 5);
      pc = 32'h0000_5000 | {25'd0, lf[2:0], 4'd0} | {29'd0, lf[3], 2'd0};
      step(pc, lf[9:8] != 2'b00, lf[15:12] != 4'h0, lf[19:16] == 4'h0);
    end

    // R11: reset mid-run empties everything again
    do_reset();
    probe("R11", 32'h0000_1004);
    probe("R11", 32'h0000_5014);
    probe("R11", 32'h0000_2108);

    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

endmodule